// File: doc/BRIEF.md
# Pipelined 4x4 Adjugate and Determinant Unit

This block takes a 4x4 matrix of signed two's-complement fixed-point entries and produces, at a fixed latency, the exact determinant and all sixteen entries of the adjugate. The adjugate is the transposed cofactor matrix. Dividing the adjugate by the determinant gives the inverse. That division is left to the consumer, so the block delivers the numerators and the common denominator of the inverse with no rounding.

All cofactors are formed at the same time. The datapath builds 2x2 sub-determinants of the lower rows, then combines them into 3x3 minors, then expands the determinant along row 0 using cofactors it has already computed. Every stage is registered, so a new matrix can be presented on every clock. Intermediate widths grow so that no product or sum can wrap. A flag beside the result marks a singular matrix.

Top module: `mat4_adjugate`

## Requirements
- R1: After a synchronous active-high reset, out_valid and out_singular are low. A matrix accepted before the reset never produces a result.
- R2: A matrix accepted with in_valid high at a rising edge shows up with out_valid high exactly 5 rising edges later. A cycle with in_valid low produces no result, whatever in_mat carries.
- R3: Input entry (r,c) is the signed DW-bit field in_mat[(4r+c)*DW +: DW]. Output entry (i,j) is the signed (3DW+3)-bit field out_adj[(4i+j)*(3DW+3) +: 3DW+3]. It equals (-1)^(i+j) times the determinant of the 3x3 matrix left when row j and column i are removed from the input.
- R4: out_det is the exact signed determinant of the input matrix, 4DW+5 bits wide.
- R5: out_singular is high exactly when out_valid is high and out_det is zero. It is low whenever out_valid is low.
- R6: Matrices presented on consecutive cycles each yield their own result, in order, on consecutive cycles.
- R7: Results are exact for every input value, including all entries at -2^(DW-1). No adjugate entry exceeds the range of 3DW+1 signed bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_mat for this cycle |
| in_mat | input | 16*DW | Sixteen signed entries, row-major |
| out_valid | output | 1 | Qualifies the result buses |
| out_adj | output | 16*(3*DW+3) | Sixteen signed adjugate entries, row-major |
| out_det | output | 4*DW+5 | Signed determinant |
| out_singular | output | 1 | High with out_valid when the determinant is zero |

## Verification
The bench builds the unit with DW = 8. At that width the most negative entry, -128, can be applied directly. Cofactors are 27 bits and the determinant is 37 bits, so a 64-bit reference model holds every result exactly: cofactors by the rule of Sarrus and the determinant by a full 24-permutation sum. Some random matrices draw entries from a narrow range or copy one row onto another, so singular results occur often. Gaps in the input stream and a reset in the middle of the stream exercise the valid pipeline.

// File: rtl/mat4_pkg.sv
package mat4_pkg;
  // k-th index in 0..3 once index excl has been removed
  function automatic int skip_idx(input int excl, input int k);
    return (k < excl) ? k : k + 1;
  endfunction

  // column pairs (a<b) enumerated 0..5
  function automatic int pair_lo(input int p);
    return (p < 3) ? 0 : ((p < 5) ? 1 : 2);
  endfunction

  function automatic int pair_hi(input int p);
    case (p)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int pair_of(input int a, input int b);
    return (a == 0) ? b - 1 : ((a == 1) ? b + 1 : 5);
  endfunction

  // which lower row pair (among rows 1..3) a cofactor of row i uses
  function automatic int row_pair_sel(input int i);
    return (i <= 1) ? 0 : i - 1;
  endfunction
endpackage

// File: rtl/valid_pipe.sv
module valid_pipe #(
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [DEPTH-1:0] taps
);
  always_ff @(posedge clk) begin
    if (rst) taps <= '0;
    else     taps <= {taps[DEPTH-2:0], din};
  end
endmodule

// File: rtl/minor2_bank.sv
module minor2_bank
  import mat4_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic signed [DW-1:0]    ent [16],
  output logic signed [2*DW:0]    d2  [3][6]
);
  localparam int PW = 2 * DW + 1;

  for (genvar t = 0; t < 3; t++) begin : g_rows
    localparam int RA = skip_idx(t, 0) + 1;
    localparam int RB = skip_idx(t, 1) + 1;
    for (genvar p = 0; p < 6; p++) begin : g_cols
      localparam int CA = pair_lo(p);
      localparam int CB = pair_hi(p);
      logic signed [PW-1:0] aa, ab, ba, bb, q;
      assign aa = ent[RA*4+CA];
      assign ab = ent[RA*4+CB];
      assign ba = ent[RB*4+CA];
      assign bb = ent[RB*4+CB];
      always_ff @(posedge clk) begin
        if (en) q <= aa * bb - ab * ba;
      end
      assign d2[t][p] = q;
    end
  end
endmodule

// File: rtl/cofactor_bank.sv
module cofactor_bank
  import mat4_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    chk_v,
  input  logic signed [2*DW:0]    d2   [3][6],
  input  logic signed [DW-1:0]    top2 [8],
  output logic signed [3*DW+2:0]  cof  [16]
);
  localparam int CW = 3 * DW + 3;

  for (genvar i = 0; i < 4; i++) begin : g_i
    localparam int R0 = skip_idx(i, 0);
    localparam int T  = row_pair_sel(i);
    for (genvar j = 0; j < 4; j++) begin : g_j
      localparam int C0 = skip_idx(j, 0);
      localparam int C1 = skip_idx(j, 1);
      localparam int C2 = skip_idx(j, 2);
      localparam bit NEG = ((i + j) % 2) == 1;
      logic signed [CW-1:0] e0, e1, e2, s0, s1, s2, minor, q;
      assign e0 = top2[R0*4+C0];
      assign e1 = top2[R0*4+C1];
      assign e2 = top2[R0*4+C2];
      assign s0 = d2[T][pair_of(C1, C2)];
      assign s1 = d2[T][pair_of(C0, C2)];
      assign s2 = d2[T][pair_of(C0, C1)];
      assign minor = e0 * s0 - e1 * s1 + e2 * s2;
      always_ff @(posedge clk) begin
        if (en) q <= NEG ? -minor : minor;
      end
      assign cof[i*4+j] = q;

      // R7: the top bits of each cofactor only ever copy its sign
      p_cof_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        chk_v |-> ((&q[CW-1:3*DW]) || !(|q[CW-1:3*DW])));
    end
  end
endmodule

// File: rtl/det_accum.sv
module det_accum #(
  parameter int DW = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en4,
  input  logic                       en5,
  input  logic                       v3,
  input  logic signed [3*DW+2:0]     cof  [16],
  input  logic signed [DW-1:0]       top3 [4],
  output logic [16*(3*DW+3)-1:0]     adj,
  output logic signed [4*DW+4:0]     det,
  output logic                       singular
);
  localparam int CW   = 3 * DW + 3;
  localparam int DETW = 4 * DW + 5;

  logic signed [DETW-1:0] rw  [4];
  logic signed [DETW-1:0] c0w [4];
  logic signed [DETW-1:0] c1w [4];
  logic signed [DETW-1:0] prod [4];
  logic signed [CW-1:0]   cof4 [16];
  logic signed [DETW-1:0] sum, alien;

  for (genvar j = 0; j < 4; j++) begin : g_w
    assign rw[j]  = top3[j];
    assign c0w[j] = cof[j];
    assign c1w[j] = cof[4+j];
  end

  always_ff @(posedge clk) begin
    if (en4) begin
      for (int j = 0; j < 4; j++) prod[j] <= rw[j] * c0w[j];
      for (int k = 0; k < 16; k++) cof4[k] <= cof[k];
    end
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < 4; j++) sum = sum + prod[j];
  end

  always_ff @(posedge clk) begin
    if (en5) begin
      det <= sum;
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          adj[(i*4+j)*CW +: CW] <= cof4[j*4+i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) singular <= 1'b0;
    else     singular <= en5 && (sum == '0);
  end

  // expansion of row 0 against the cofactors of row 1 must vanish
  always_comb begin
    alien = '0;
    for (int j = 0; j < 4; j++) alien = alien + rw[j] * c1w[j];
  end

  // R3: cofactors and delayed row-0 entries agree with each other
  p_alien_rows_zero_r3: assert property (@(posedge clk) disable iff (rst)
    v3 |-> (alien == '0));
endmodule

// File: rtl/mat4_adjugate.sv
module mat4_adjugate #(
  parameter int DW = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [16*DW-1:0]        in_mat,
  output logic                    out_valid,
  output logic [16*(3*DW+3)-1:0]  out_adj,
  output logic [4*DW+4:0]         out_det,
  output logic                    out_singular
);
  localparam int CW   = 3 * DW + 3;
  localparam int DETW = 4 * DW + 5;
  localparam int LAT  = 5;

  logic [LAT-1:0]         vtap;
  logic signed [DW-1:0]   ent1 [16];
  logic signed [DW-1:0]   ent2 [8];
  logic signed [DW-1:0]   ent3 [4];
  logic signed [2*DW:0]   d2   [3][6];
  logic signed [CW-1:0]   cof  [16];
  logic signed [DETW-1:0] det_s;

  valid_pipe #(.DEPTH(LAT)) u_vp (
    .clk (clk), .rst (rst), .din (in_valid), .taps (vtap)
  );

  always_ff @(posedge clk) begin
    if (in_valid)
      for (int k = 0; k < 16; k++) ent1[k] <= in_mat[k*DW +: DW];
    if (vtap[0])
      for (int k = 0; k < 8; k++) ent2[k] <= ent1[k];
    if (vtap[1])
      for (int k = 0; k < 4; k++) ent3[k] <= ent2[k];
  end

  minor2_bank #(.DW(DW)) u_m2 (
    .clk (clk), .en (vtap[0]), .ent (ent1), .d2 (d2)
  );

  cofactor_bank #(.DW(DW)) u_cf (
    .clk (clk), .rst (rst), .en (vtap[1]), .chk_v (vtap[2]),
    .d2 (d2), .top2 (ent2), .cof (cof)
  );

  det_accum #(.DW(DW)) u_da (
    .clk (clk), .rst (rst), .en4 (vtap[2]), .en5 (vtap[3]), .v3 (vtap[2]),
    .cof (cof), .top3 (ent3), .adj (out_adj), .det (det_s),
    .singular (out_singular)
  );

  assign out_det   = det_s;
  assign out_valid = vtap[LAT-1];

  // R1: nothing leaves in the first cycle after reset
  p_valid_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_singular));

  // R2: every result traces back to an accepted matrix five edges earlier
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 5));

  // R5: the flag agrees with the delivered determinant
  p_singular_match_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_singular == (out_det == '0)));

  p_singular_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_singular);
endmodule

// File: tb/sim_mat4_adjugate.sv
module sim_mat4_adjugate;
  localparam int DW         = 8;
  localparam int CW         = 3 * DW + 3;
  localparam int DETW       = 4 * DW + 5;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 5;
  localparam int NV         = 600;
  localparam int WATCHDOG   = 20000;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  in_valid = 1'b0;
  logic [16*DW-1:0]      in_mat = '0;
  logic                  out_valid;
  logic [16*CW-1:0]      out_adj;
  logic [DETW-1:0]       out_det;
  logic                  out_singular;

  mat4_adjugate #(.DW(DW)) u0 (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_mat (in_mat),
    .out_valid (out_valid), .out_adj (out_adj), .out_det (out_det),
    .out_singular (out_singular)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint e_adj [NV][16];
  longint e_det [NV];
  int     iss   [NV];
  int     wr = 0, rd = 0;
  int     checks = 0, fails = 0;
  bit     done = 1'b0;
  longint mm [16];

  function automatic longint cofac(input longint mx[16], input int i, input int j);
    longint s [9];
    longint d;
    int n = 0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (r != i && c != j) begin
          s[n] = mx[r*4+c];
          n = n + 1;
        end
    d = s[0]*s[4]*s[8] + s[1]*s[5]*s[6] + s[2]*s[3]*s[7]
      - s[2]*s[4]*s[6] - s[0]*s[5]*s[7] - s[1]*s[3]*s[8];
    return ((i + j) % 2 == 1) ? -d : d;
  endfunction

  function automatic longint det4(input longint mx[16]);
    longint acc = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              int inv;
              longint t;
              inv = int'(a > b) + int'(a > c) + int'(a > d)
                  + int'(b > c) + int'(b > d) + int'(c > d);
              t = mx[a] * mx[4+b] * mx[8+c] * mx[12+d];
              acc = (inv % 2 == 1) ? acc - t : acc + t;
            end
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)",
               req, what, act, exp, cyc);
    end
  endtask

  task automatic push(input longint mx[16], input bit keep);
    @(negedge clk);
    in_valid = 1'b1;
    for (int k = 0; k < 16; k++) in_mat[k*DW +: DW] = DW'(mx[k]);
    if (keep) begin
      iss[wr] = cyc;
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          e_adj[wr][i*4+j] = cofac(mx, j, i);
      e_det[wr] = det4(mx);
      wr = wr + 1;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < 16; k++) in_mat[k*DW +: DW] = DW'($urandom);
    end
  endtask

  function automatic longint rnd_full();
    return longint'($urandom_range(0, (1 << DW) - 1)) - longint'(1 << (DW - 1));
  endfunction

  // monitor: R2 timing, R3/R4/R5 values, R6 ordering
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit exp_v;
      exp_v = (rd < wr) && (iss[rd] + LAT == cyc);
      check(out_valid == exp_v, "R2", "out_valid",
            longint'(out_valid), longint'(exp_v));
      if (!out_valid)
        check(!out_singular, "R5", "idle singular", longint'(out_singular), 0);
      if (exp_v) begin
        if (out_valid) begin
          for (int k = 0; k < 16; k++) begin
            longint a;
            a = longint'($signed(out_adj[k*CW +: CW]));
            check(a == e_adj[rd][k], "R3", $sformatf("adj[%0d] vec %0d", k, rd),
                  a, e_adj[rd][k]);
          end
          check(longint'($signed(out_det)) == e_det[rd], "R4",
                $sformatf("det vec %0d", rd), longint'($signed(out_det)), e_det[rd]);
          check(out_singular == (e_det[rd] == 0), "R5",
                $sformatf("singular vec %0d", rd), longint'(out_singular),
                longint'(e_det[rd] == 0));
        end
        rd = rd + 1;
      end
    end
  end

  initial begin
    void'($urandom(32'd4417));
    repeat (4) @(negedge clk);
    check(!out_valid, "R1", "valid during reset", longint'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !out_singular, "R1", "valid/singular after reset",
          longint'({out_valid, out_singular}), 0);

    // identity
    for (int k = 0; k < 16; k++) mm[k] = (k % 5 == 0) ? 1 : 0;
    push(mm, 1);
    // zero matrix: singular, all cofactors zero (R5)
    for (int k = 0; k < 16; k++) mm[k] = 0;
    push(mm, 1);
    // every entry at the most negative value (R7)
    for (int k = 0; k < 16; k++) mm[k] = -(1 << (DW - 1));
    push(mm, 1);
    // diagonal of most negative values (R7)
    for (int k = 0; k < 16; k++) mm[k] = (k % 5 == 0) ? -(1 << (DW - 1)) : 0;
    push(mm, 1);
    // row swap permutation, det -1
    for (int k = 0; k < 16; k++) mm[k] = 0;
    mm[1] = 1; mm[4] = 1; mm[10] = 1; mm[15] = 1;
    push(mm, 1);
    // duplicate rows: singular with nonzero cofactors possible
    for (int k = 0; k < 16; k++) mm[k] = rnd_full();
    for (int c = 0; c < 4; c++) mm[12+c] = mm[4+c];
    push(mm, 1);
    // alternating extremes
    for (int k = 0; k < 16; k++)
      mm[k] = ((k + k / 4) % 2 == 0) ? (1 << (DW - 1)) - 1 : -(1 << (DW - 1));
    push(mm, 1);
    idle(10);

    // R1: reset in the middle of the stream drops matrices in flight
    for (int k = 0; k < 16; k++) mm[k] = rnd_full();
    push(mm, 0);
    push(mm, 0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (8) begin
      @(negedge clk);
      check(!out_valid, "R1", "dropped after mid reset", longint'(out_valid), 0);
    end

    // random stream, back-to-back with occasional gaps (R6)
    for (int v = 0; v < 420; v++) begin
      int mode;
      mode = $urandom_range(0, 3);
      for (int k = 0; k < 16; k++) begin
        case (mode)
          0: mm[k] = rnd_full();
          1: mm[k] = longint'($urandom_range(0, 4)) - 2;
          2: begin
            int s;
            s = $urandom_range(0, 2);
            mm[k] = (s == 0) ? -(1 << (DW - 1)) : ((s == 1) ? (1 << (DW - 1)) - 1 : 0);
          end
          default: mm[k] = rnd_full();
        endcase
      end
      if (mode == 3)
        for (int c = 0; c < 4; c++) mm[8+c] = mm[c];
      push(mm, 1);
      if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
    end
    idle(12);
    check(rd == wr, "R6", "results delivered", longint'(rd), longint'(wr));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL R2 watchdog: actual %0d expected %0d", rd, wr);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule